// File: doc/BRIEF.md
# Slot Hot-Plug Interrupt Aggregator

This block gathers the six hot-plug events a slot can raise and reduces them to one interrupt request. It registers a sticky status bit for each event, masks it with a per-event enable and a master hot-plug gate, and steers the result. The request goes either to a message-signalled interrupt request or to a legacy level interrupt line. A separate pair of wake outputs, each with its own enable, carries the same gated condition.

Slot monitors deliver the events as pulses. Software sees three small registers through a plain write strobe and an address, with read data returned combinationally. Status bits are cleared by writing 1 to them.

Top module: `hp_irq_agg`

## Requirements
- R1: After reset all enables, the master gate, the routing bits and all status bits read 0, and `intx_o`, `msi_req_o`, `pme_req_o` and `gpe_req_o` are low.
- R2: Register map. Address 0 holds the event enables in bits 5:0 and the master gate in bit 6. Address 1 holds the status in bits 5:0. Address 2 holds msi_en in bit 0, intx_dis in bit 1, pme_en in bit 2 and gpe_en in bit 3. Address 3 reads 0. Unused read bits are 0. Event bit order: 0 command done, 1 attention button, 2 power fault, 3 retention latch sensor changed, 4 presence changed, 5 link state changed.
- R3: A status bit is set by the clock edge that samples a 0-to-1 change of its event input, whatever its enable. An input held high sets the bit only once.
- R4: Writing 1 to a status bit at address 1 clears it in that write's clock edge. Writing 0 leaves the bit unchanged.
- R5: When an event's rising edge and a write-1 clear of the same bit fall in the same cycle, the bit ends up set.
- R6: The pending condition is: master gate set AND some status bit set whose enable is also set. With msi_en=0 and intx_dis=0, `intx_o` is high exactly while pending is true, and it drops once the enabled status bits are cleared.
- R7: With intx_dis=1, or with msi_en=1, `intx_o` stays low while pending is true.
- R8: With msi_en=1, `msi_req_o` is high for exactly one cycle. That cycle comes after the clock edge at which pending turns from false to true.
- R9: With msi_en=1 and pending already true, a further one-cycle `msi_req_o` pulse follows the setting of a new enabled status bit. No pulse follows a disabled bit being set, or a repeated event on a bit that is already set.
- R10: `pme_req_o` equals pending AND pme_en, and `gpe_req_o` equals pending AND gpe_en. This holds whatever the MSI and INTx routing.
- R11: With the master gate clear, none of the four request outputs rises, even with enabled status bits set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| evt_pulse_i | input | 6 | Event inputs from the slot monitors, bit order as in R2 |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 7 | Register write data |
| reg_rdata_o | output | 7 | Register read data for `reg_addr_i`, combinational |
| intx_o | output | 1 | Legacy level interrupt |
| msi_req_o | output | 1 | One-cycle message interrupt request |
| pme_req_o | output | 1 | Power-management wake request |
| gpe_req_o | output | 1 | General-purpose event request |

## Verification
The bench targets the cycle where an event edge and a clear of the same bit coincide. A design that lets the clear win would lose the event and read 0. It holds an event input high across a clear. A level-sensitive design would set the bit again at once. It sends repeated and disabled events while MSI is already pending. A design that pulses on every event, or on none after the first, gives the wrong pulse count. Finally, it checks that INTx stays quiet under MSI routing or intx_dis, and that nothing fires with the master gate off, so outputs that ignore those bits show up as stray requests.

// File: rtl/hp_irq_pkg.sv
// Package: shared constants, register addresses and routing-field type
// for the slot hot-plug interrupt aggregator.
package hp_irq_pkg;
    localparam int unsigned NUM_EVT    = 6;
    localparam int unsigned DATA_W     = NUM_EVT + 1;
    localparam int unsigned ADDR_W     = 2;
    localparam int unsigned MASTER_BIT = NUM_EVT;
    localparam int unsigned ROUTE_W    = 4;

    typedef enum logic [ADDR_W-1:0] {
        ADDR_SLOT_CTL = 2'd0,
        ADDR_SLOT_STS = 2'd1,
        ADDR_ROUTE    = 2'd2,
        ADDR_RSVD     = 2'd3
    } reg_addr_e;

    // Routing controls, packed so that msi_en sits in bit 0.
    typedef struct packed {
        logic gpe_en;
        logic pme_en;
        logic intx_dis;
        logic msi_en;
    } route_t;
endpackage

// File: rtl/hp_evt_cell.sv
// Module: hp_evt_cell
// One sticky status bit. It sets on a rising edge of its event input and
// clears on a write-1 strobe; a set in the same cycle as a clear wins.
// Assumes the event input is synchronous to clk_i.
module hp_evt_cell (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic evt_i,
    input  logic clr_i,
    output logic rise_o,
    output logic sts_d_o,
    output logic sts_q_o
);
    logic prev_q;

    // Edge detect and next status value
    always_comb begin
        rise_o  = evt_i & ~prev_q;
        sts_d_o = rise_o | (sts_q_o & ~clr_i);
    end

    // State update
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q  <= 1'b0;
            sts_q_o <= 1'b0;
        end else begin
            prev_q  <= evt_i;
            sts_q_o <= sts_d_o;
        end
    end
endmodule

// File: rtl/hp_evt_bank.sv
// Module: hp_evt_bank
// Replicates one status cell per slot event. Exposes the current status,
// the next status and the edge vector so the router can see this cycle's changes.
// Assumes clr_mask_i is already qualified by a status-register write.
module hp_evt_bank
    import hp_irq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_i,
    input  logic [NUM_EVT-1:0] clr_mask_i,
    output logic [NUM_EVT-1:0] rise_o,
    output logic [NUM_EVT-1:0] sts_d_o,
    output logic [NUM_EVT-1:0] sts_q_o
);
    for (genvar k = 0; k < NUM_EVT; k++) begin : g_cell
        hp_evt_cell cell_i (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .evt_i   (evt_i[k]),
            .clr_i   (clr_mask_i[k]),
            .rise_o  (rise_o[k]),
            .sts_d_o (sts_d_o[k]),
            .sts_q_o (sts_q_o[k])
        );
    end
endmodule

// File: rtl/hp_ctrl_regs.sv
// Module: hp_ctrl_regs
// Holds the per-event enables, the master gate and the routing bits.
// Provides both current and next values. Assumes a single write strobe
// with the address decoded here.
module hp_ctrl_regs
    import hp_irq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               wr_i,
    input  logic [ADDR_W-1:0]  addr_i,
    input  logic [DATA_W-1:0]  wdata_i,
    output logic [NUM_EVT-1:0] en_q_o,
    output logic [NUM_EVT-1:0] en_d_o,
    output logic               master_q_o,
    output logic               master_d_o,
    output route_t             route_q_o,
    output route_t             route_d_o
);
    logic ctl_we;
    logic route_we;

    // Address decode and next-state selection
    always_comb begin
        ctl_we     = wr_i && (addr_i == ADDR_SLOT_CTL);
        route_we   = wr_i && (addr_i == ADDR_ROUTE);
        en_d_o     = ctl_we   ? wdata_i[NUM_EVT-1:0]   : en_q_o;
        master_d_o = ctl_we   ? wdata_i[MASTER_BIT]     : master_q_o;
        route_d_o  = route_we ? route_t'(wdata_i[ROUTE_W-1:0]) : route_q_o;
    end

    // Register update
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            en_q_o     <= '0;
            master_q_o <= 1'b0;
            route_q_o  <= '0;
        end else begin
            en_q_o     <= en_d_o;
            master_q_o <= master_d_o;
            route_q_o  <= route_d_o;
        end
    end
endmodule

// File: rtl/hp_irq_router.sv
// Module: hp_irq_router
// Forms the gated pending condition and steers it to INTx (level), MSI
// (one-cycle pulse) and the two wake levels. The MSI pulse is registered
// from next-state values, so it lines up with the status it reports.
module hp_irq_router
    import hp_irq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] sts_q_i,
    input  logic [NUM_EVT-1:0] sts_d_i,
    input  logic [NUM_EVT-1:0] en_q_i,
    input  logic [NUM_EVT-1:0] en_d_i,
    input  logic               master_q_i,
    input  logic               master_d_i,
    input  route_t             route_q_i,
    input  route_t             route_d_i,
    output logic               pend_o,
    output logic               intx_o,
    output logic               msi_o,
    output logic               pme_o,
    output logic               gpe_o
);
    logic pend_nxt;
    logic new_enabled;

    // Pending condition now and next, plus newly set enabled bits
    always_comb begin
        pend_o      = master_q_i & (|(sts_q_i & en_q_i));
        pend_nxt    = master_d_i & (|(sts_d_i & en_d_i));
        new_enabled = |(sts_d_i & ~sts_q_i & en_d_i);
    end

    // Level outputs from current state
    always_comb begin
        intx_o = pend_o & ~route_q_i.msi_en & ~route_q_i.intx_dis;
        pme_o  = pend_o & route_q_i.pme_en;
        gpe_o  = pend_o & route_q_i.gpe_en;
    end

    // MSI pulse on pending rise or on a new enabled event
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            msi_o <= 1'b0;
        end else begin
            msi_o <= route_d_i.msi_en & pend_nxt & (~pend_o | new_enabled);
        end
    end
endmodule

// File: rtl/hp_irq_agg.sv
// Module: hp_irq_agg (top)
// Slot hot-plug interrupt aggregator: status bank, control registers,
// router and a combinational register readback.
// Assumes all inputs are synchronous to clk_i; reset is synchronous, active low.
module hp_irq_agg
    import hp_irq_pkg::*;
(
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_EVT-1:0] evt_pulse_i,
    input  logic               reg_wr_i,
    input  logic [ADDR_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0]  reg_wdata_i,
    output logic [DATA_W-1:0]  reg_rdata_o,
    output logic               intx_o,
    output logic               msi_req_o,
    output logic               pme_req_o,
    output logic               gpe_req_o
);
    logic [NUM_EVT-1:0] clr_mask;
    logic [NUM_EVT-1:0] evt_rise;
    logic [NUM_EVT-1:0] sts_d;
    logic [NUM_EVT-1:0] sts_q;
    logic [NUM_EVT-1:0] en_q;
    logic [NUM_EVT-1:0] en_d;
    logic               master_q;
    logic               master_d;
    route_t             route_q;
    route_t             route_d;
    logic               pend;

    // Write-1-clear mask for the status register
    always_comb begin
        clr_mask = (reg_wr_i && (reg_addr_i == ADDR_SLOT_STS))
                 ? reg_wdata_i[NUM_EVT-1:0] : '0;
    end

    hp_evt_bank bank_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .evt_i      (evt_pulse_i),
        .clr_mask_i (clr_mask),
        .rise_o     (evt_rise),
        .sts_d_o    (sts_d),
        .sts_q_o    (sts_q)
    );

    hp_ctrl_regs regs_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .wr_i       (reg_wr_i),
        .addr_i     (reg_addr_i),
        .wdata_i    (reg_wdata_i),
        .en_q_o     (en_q),
        .en_d_o     (en_d),
        .master_q_o (master_q),
        .master_d_o (master_d),
        .route_q_o  (route_q),
        .route_d_o  (route_d)
    );

    hp_irq_router router_i (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sts_q_i    (sts_q),
        .sts_d_i    (sts_d),
        .en_q_i     (en_q),
        .en_d_i     (en_d),
        .master_q_i (master_q),
        .master_d_i (master_d),
        .route_q_i  (route_q),
        .route_d_i  (route_d),
        .pend_o     (pend),
        .intx_o     (intx_o),
        .msi_o      (msi_req_o),
        .pme_o      (pme_req_o),
        .gpe_o      (gpe_req_o)
    );

    // Register readback mux
    always_comb begin
        reg_rdata_o = '0;
        case (reg_addr_i)
            ADDR_SLOT_CTL: begin
                reg_rdata_o[NUM_EVT-1:0] = en_q;
                reg_rdata_o[MASTER_BIT]  = master_q;
            end
            ADDR_SLOT_STS: reg_rdata_o[NUM_EVT-1:0] = sts_q;
            ADDR_ROUTE:    reg_rdata_o[ROUTE_W-1:0] = route_q;
            default:       reg_rdata_o = '0;
        endcase
    end
endmodule

// File: rtl/hp_irq_agg_chk.sv
// Module: hp_irq_agg_chk
// Property checker bound into hp_irq_agg. It watches the status bank,
// the control state and the request outputs.
module hp_irq_agg_chk
    import hp_irq_pkg::*;
(
    input logic               clk_i,
    input logic               rst_ni,
    input logic               reg_wr_i,
    input logic [ADDR_W-1:0]  reg_addr_i,
    input logic [DATA_W-1:0]  reg_wdata_i,
    input logic [NUM_EVT-1:0] evt_rise,
    input logic [NUM_EVT-1:0] sts_q,
    input logic               master_q,
    input route_t             route_q,
    input logic               pend,
    input logic               intx_o,
    input logic               msi_req_o,
    input logic               pme_req_o,
    input logic               gpe_req_o
);
    logic [NUM_EVT-1:0] wr_clr;

    // Clear mask seen at the ports
    always_comb begin
        wr_clr = (reg_wr_i && (reg_addr_i == ADDR_SLOT_STS))
               ? reg_wdata_i[NUM_EVT-1:0] : '0;
    end

    // R3 / R5: an edge always leaves its status bit set
    a_r3_edge_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (evt_rise != '0) |=> ((sts_q & $past(evt_rise)) == $past(evt_rise)));

    // R4: a set bit only falls when a 1 was written to it
    a_r4_clear_only_by_w1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (sts_q != '0) |=> ((($past(sts_q) & ~$past(wr_clr)) & ~sts_q) == '0));

    // R7: INTx never asserts under MSI routing or with intx_dis set
    a_r7_intx_routing: assert property (@(posedge clk_i) disable iff (!rst_ni)
        intx_o |-> (pend && !route_q.msi_en && !route_q.intx_dis));

    // R8: MSI request only while routed to MSI and pending
    a_r8_msi_routed: assert property (@(posedge clk_i) disable iff (!rst_ni)
        msi_req_o |-> (route_q.msi_en && pend));

    // R11: master gate off keeps every request low
    a_r11_master_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !master_q |-> !(intx_o || msi_req_o || pme_req_o || gpe_req_o));

    // R10: wake outputs only while pending
    a_r10_wake_needs_pend: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pme_req_o || gpe_req_o) |-> pend);
endmodule

bind hp_irq_agg hp_irq_agg_chk chk_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_wr_i    (reg_wr_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .evt_rise    (evt_rise),
    .sts_q       (sts_q),
    .master_q    (master_q),
    .route_q     (route_q),
    .pend        (pend),
    .intx_o      (intx_o),
    .msi_req_o   (msi_req_o),
    .pme_req_o   (pme_req_o),
    .gpe_req_o   (gpe_req_o)
);

// File: tb/hp_irq_agg_tb_top.sv
`timescale 1ns/1ps
// Directed bench for hp_irq_agg. Inputs change on the falling edge,
// and results are sampled on the falling edge after the active edge.
module hp_irq_agg_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] evt = '0;
    logic       wr = 1'b0;
    logic [1:0] addr = '0;
    logic [6:0] wdata = '0;
    logic [6:0] rdata;
    logic       intx, msi, pme, gpe;
    int         checks = 0;
    int         errors = 0;

    always #4 clk = ~clk;

    hp_irq_agg dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .evt_pulse_i (evt),
        .reg_wr_i    (wr),
        .reg_addr_i  (addr),
        .reg_wdata_i (wdata),
        .reg_rdata_o (rdata),
        .intx_o      (intx),
        .msi_req_o   (msi),
        .pme_req_o   (pme),
        .gpe_req_o   (gpe)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [6:0] d);
        @(negedge clk);
        wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [6:0] d);
        addr = a;
        #1 d = rdata;
    endtask

    task automatic pulse(input logic [5:0] m);
        @(negedge clk);
        evt = m;
        @(negedge clk);
        evt = '0;
    endtask

    task automatic outs_all(input string req, input logic [3:0] exp);
        chk(req, {intx, msi, pme, gpe}, exp);
    endtask

    task automatic cleanup();
        wr_reg(2'd0, 7'h00);
        wr_reg(2'd2, 7'h00);
        wr_reg(2'd1, 7'h3F);
    endtask

    task automatic t_reset();
        logic [6:0] d;
        for (int a = 0; a < 4; a++) begin
            rd_reg(2'(a), d);
            chk("R1 reset reg", d, 0);
        end
        outs_all("R1 reset outputs", 4'b0000);
    endtask

    task automatic t_regmap();
        logic [6:0] d;
        wr_reg(2'd0, 7'h55); rd_reg(2'd0, d); chk("R2 ctl readback", d, 'h55);
        wr_reg(2'd2, 7'h7A); rd_reg(2'd2, d); chk("R2 route readback masked", d, 'h0A);
        wr_reg(2'd3, 7'h7F); rd_reg(2'd3, d); chk("R2 reserved reads 0", d, 0);
        rd_reg(2'd0, d); chk("R2 ctl untouched by reserved write", d, 'h55);
        cleanup();
    endtask

    task automatic t_set_no_enable();
        logic [6:0] d;
        pulse(6'b100100);
        rd_reg(2'd1, d); chk("R3 set with enables clear", d, 'h24);
        wr_reg(2'd1, 7'h3F);
        @(negedge clk); evt = 6'b000001;
        repeat (3) @(negedge clk);
        rd_reg(2'd1, d); chk("R3 held input sets once", d, 'h01);
        wr_reg(2'd1, 7'h01);
        repeat (2) @(negedge clk);
        rd_reg(2'd1, d); chk("R3 held input no retrigger", d, 0);
        evt = '0;
        cleanup();
    endtask

    task automatic t_w1c();
        logic [6:0] d;
        pulse(6'b111111);
        wr_reg(2'd1, 7'h00); rd_reg(2'd1, d); chk("R4 write 0 no effect", d, 'h3F);
        wr_reg(2'd1, 7'h05); rd_reg(2'd1, d); chk("R4 write 1 clears", d, 'h3A);
        cleanup();
    endtask

    task automatic t_collision();
        logic [6:0] d;
        pulse(6'b000010);
        @(negedge clk);
        evt = 6'b000010; wr = 1'b1; addr = 2'd1; wdata = 7'h02;
        @(negedge clk);
        evt = '0; wr = 1'b0; wdata = '0;
        rd_reg(2'd1, d); chk("R5 set beats clear", d, 'h02);
        cleanup();
    endtask

    task automatic t_intx();
        wr_reg(2'd0, 7'h44);
        pulse(6'b000100);
        outs_all("R6 intx asserted", 4'b1000);
        pulse(6'b000001);
        outs_all("R6 intx still asserted", 4'b1000);
        wr_reg(2'd1, 7'h04);
        outs_all("R6 intx drops, disabled bit left", 4'b0000);
        cleanup();
    endtask

    task automatic t_intx_dis();
        wr_reg(2'd2, 7'h02);
        wr_reg(2'd0, 7'h41);
        pulse(6'b000001);
        outs_all("R7 intx_dis blocks", 4'b0000);
        cleanup();
    endtask

    task automatic t_msi();
        wr_reg(2'd2, 7'h01);
        wr_reg(2'd0, 7'h48);
        pulse(6'b001000);
        outs_all("R8 msi pulse, no intx", 4'b0100);
        @(negedge clk);
        outs_all("R8 msi one cycle", 4'b0000);
        wr_reg(2'd1, 7'h08);
        wr_reg(2'd0, 7'h08);
        pulse(6'b001000);
        outs_all("R8 no pulse, gate off", 4'b0000);
        wr_reg(2'd0, 7'h48);
        outs_all("R8 pulse on gate enable", 4'b0100);
        @(negedge clk);
        outs_all("R8 pulse ends", 4'b0000);
        cleanup();
    endtask

    task automatic t_msi_second();
        wr_reg(2'd2, 7'h01);
        wr_reg(2'd0, 7'h43);
        pulse(6'b000001);
        outs_all("R9 first pulse", 4'b0100);
        pulse(6'b000010);
        outs_all("R9 second pulse new enabled", 4'b0100);
        pulse(6'b000100);
        outs_all("R9 disabled bit no pulse", 4'b0000);
        pulse(6'b000001);
        outs_all("R9 already set no pulse", 4'b0000);
        cleanup();
    endtask

    task automatic t_wake();
        wr_reg(2'd2, 7'h0D);
        wr_reg(2'd0, 7'h60);
        pulse(6'b100000);
        outs_all("R10 msi plus wake", 4'b0111);
        @(negedge clk);
        outs_all("R10 wake levels hold", 4'b0011);
        wr_reg(2'd2, 7'h04);
        outs_all("R10 pme only with intx", 4'b1010);
        cleanup();
    endtask

    task automatic t_master();
        wr_reg(2'd2, 7'h0C);
        wr_reg(2'd0, 7'h3F);
        pulse(6'b111111);
        outs_all("R11 master off all low", 4'b0000);
        @(negedge clk);
        outs_all("R11 master off still low", 4'b0000);
        cleanup();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regmap();
        t_set_no_enable();
        t_w1c();
        t_collision();
        t_intx();
        t_intx_dis();
        t_msi();
        t_msi_second();
        t_wake();
        t_master();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule